// File: doc/BRIEF.md
# Signed-Magnitude Adder/Subtractor

This is a purely combinational unit. It adds or subtracts two operands held in signed-magnitude form. In each operand the top bit holds the sign and the lower bits hold an unsigned magnitude. The unit separates the signs from the magnitudes. A subtraction is turned into an addition by flipping the sign of the second operand.

When the two effective signs agree, the magnitudes are added and the common sign is kept. When the signs differ, the second magnitude is subtracted from the first. If that subtraction ends with a borrow, the raw difference is turned into its two's complement and the sign of the first operand is flipped. The result is then packed back into signed-magnitude form, and a zero magnitude always carries a positive sign.

A single flag reports that a magnitude sum did not fit in the magnitude field.

Top module: `smag_addsub`

## Requirements
- R1: Bit WIDTH-1 of each operand and of the result is the sign (0 positive, 1 negative); bits WIDTH-2..0 form an unsigned magnitude, so at 8 bits minus nine is encoded 0x89.
- R2: With sub_i=0 and equal operand signs, the result magnitude is the sum of the magnitudes and the result sign equals the sign of A.
- R3: ovf_o is 1 exactly when the effective signs agree and the magnitude sum exceeds 2^(WIDTH-1)-1; the result magnitude is then the low WIDTH-1 bits of the sum. ovf_o is 0 whenever the effective signs differ.
- R4: When the effective signs differ and |A| >= |B|, the result magnitude is |A|-|B| and the result sign is that of A.
- R5: When the effective signs differ and |B| > |A| (end borrow), the result magnitude is |B|-|A| and the result sign is the opposite of A's; at 8 bits 0x19 plus 0xA5 gives 0x8C.
- R6: sub_i=1 selects A minus B, formed by inverting B's sign bit and then applying R2 to R5.
- R7: A result with zero magnitude always has sign 0, including overflow wrap to zero and inputs carrying a negative zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand (minuend), signed-magnitude |
| b_i | input | WIDTH | Second operand, signed-magnitude |
| sub_i | input | 1 | 0 selects A+B, 1 selects A-B |
| res_o | output | WIDTH | Result, signed-magnitude |
| ovf_o | output | 1 | Magnitude overflow flag |

## Verification
The bench runs every operand pair and both operations at a 5-bit width and compares each result with signed integer arithmetic on the decoded values. This run covers the equal-magnitude cancellation that must not leave a negative zero. It also covers the wrap to zero on overflow, which a design missing the sign override would report as minus zero. It covers negative-zero inputs as well.

The borrow cases catch two faults: a missing two's-complement step, which shows up as a huge magnitude, and a missing sign flip, which shows up as a result with the wrong sign. Directed 8-bit vectors exercise the worked example and the minus-nine encoding. They also cover overflow near the top of the range, where a carry dropped or misrouted into the flag would show.

// File: rtl/smag_pkg.sv
package smag_pkg;
  typedef enum logic {
    MAG_ADD = 1'b0,
    MAG_SUB = 1'b1
  } mag_op_e;
endpackage

// File: rtl/smag_fa.sv
module smag_fa (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic p, g;
  // two half adders plus an OR
  assign p   = x_i ^ y_i;
  assign g   = x_i & y_i;
  assign s_o = p ^ c_i;
  assign c_o = g | (p & c_i);
endmodule

// File: rtl/smag_mag_unit.sv
module smag_mag_unit
  import smag_pkg::*;
#(
  parameter int MAG_W = 7
) (
  input  logic [MAG_W-1:0] x_i,
  input  logic [MAG_W-1:0] y_i,
  input  mag_op_e          op_i,
  output logic [MAG_W-1:0] raw_o,
  output logic             cout_o
);
  logic             inv;
  logic [MAG_W-1:0] y_sel;
  logic [MAG_W:0]   carry;

  assign inv      = (op_i == MAG_SUB);
  assign y_sel    = y_i ^ {MAG_W{inv}};
  assign carry[0] = inv;

  for (genvar i = 0; i < MAG_W; i++) begin : g_rip
    smag_fa fa_i (
      .x_i(x_i[i]),
      .y_i(y_sel[i]),
      .c_i(carry[i]),
      .s_o(raw_o[i]),
      .c_o(carry[i+1])
    );
  end

  assign cout_o = carry[MAG_W];
endmodule

// File: rtl/smag_negate.sv
module smag_negate #(
  parameter int MAG_W = 7
) (
  input  logic [MAG_W-1:0] in_i,
  input  logic             en_i,
  output logic [MAG_W-1:0] out_o
);
  logic [MAG_W-1:0] flip;
  logic [MAG_W:0]   inc_c;

  // invert then add en_i through an increment chain
  assign flip     = in_i ^ {MAG_W{en_i}};
  assign inc_c[0] = en_i;

  for (genvar i = 0; i < MAG_W; i++) begin : g_inc
    assign out_o[i]   = flip[i] ^ inc_c[i];
    assign inc_c[i+1] = flip[i] & inc_c[i];
  end
endmodule

// File: rtl/smag_addsub.sv
module smag_addsub
  import smag_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] res_o,
  output logic             ovf_o
);
  localparam int MAG_W = WIDTH - 1;

  logic             a_sign, b_sign_eff;
  logic [MAG_W-1:0] a_mag, b_mag, raw_mag, fix_mag;
  logic             mag_cout, borrow, res_sign, mag_zero;
  mag_op_e          mag_op;

  // R1 field split, R6 subtract folds into sign of B
  assign a_sign     = a_i[WIDTH-1];
  assign b_sign_eff = b_i[WIDTH-1] ^ sub_i;
  assign a_mag      = a_i[MAG_W-1:0];
  assign b_mag      = b_i[MAG_W-1:0];
  assign mag_op     = (a_sign == b_sign_eff) ? MAG_ADD : MAG_SUB;

  smag_mag_unit #(.MAG_W(MAG_W)) mag_i (
    .x_i   (a_mag),
    .y_i   (b_mag),
    .op_i  (mag_op),
    .raw_o (raw_mag),
    .cout_o(mag_cout)
  );

  // in subtract mode a missing carry is the end borrow (R5)
  assign borrow = (mag_op == MAG_SUB) & ~mag_cout;
  assign ovf_o  = (mag_op == MAG_ADD) &  mag_cout;

  smag_negate #(.MAG_W(MAG_W)) neg_i (
    .in_i (raw_mag),
    .en_i (borrow),
    .out_o(fix_mag)
  );

  assign mag_zero = ~|fix_mag;
  assign res_sign = (a_sign ^ borrow) & ~mag_zero; // R7 no negative zero
  assign res_o    = {res_sign, fix_mag};
endmodule

// File: rtl/smag_addsub_chk.sv
module smag_addsub_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             sub_i,
  input logic [WIDTH-1:0] res_o,
  input logic             ovf_o
);
  localparam int MAG_W = WIDTH - 1;

  logic             a_s, b_s, r_s, same;
  logic [MAG_W-1:0] a_m, b_m, r_m;

  assign a_s  = a_i[WIDTH-1];
  assign b_s  = b_i[WIDTH-1] ^ sub_i;
  assign r_s  = res_o[WIDTH-1];
  assign a_m  = a_i[MAG_W-1:0];
  assign b_m  = b_i[MAG_W-1:0];
  assign r_m  = res_o[MAG_W-1:0];
  assign same = (a_s == b_s);

  always_comb begin
    AST_ZERO_POS: assert (r_m != '0 || !r_s);                                   // R7
    AST_OVF_DIFF: assert (same || !ovf_o);                                      // R3
    AST_SUM_GROWS: assert (!same || ovf_o || (r_m >= a_m && r_m >= b_m));        // R2
    AST_SUM_SIGN: assert (!same || r_m == '0 || r_s == a_s);                     // R2
    AST_DIFF_SIGN: assert (same || a_m <= b_m || r_s == a_s);                    // R4
    AST_BORROW_SIGN: assert (same || b_m <= a_m || r_s == !a_s);                 // R5
    AST_DIFF_BOUND: assert (same || (r_m <= a_m || r_m <= b_m));                 // R4
  end
endmodule

bind smag_addsub smag_addsub_chk #(.WIDTH(WIDTH)) chk_i (
  .a_i  (a_i),
  .b_i  (b_i),
  .sub_i(sub_i),
  .res_o(res_o),
  .ovf_o(ovf_o)
);

// File: tb/smag_addsub_tb.sv
module smag_addsub_tb_top;
  localparam int SW = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic [SW-1:0] a5, b5, r5;
  logic [7:0]    a8, b8, r8;
  logic          s5, s8, o5, o8;

  smag_addsub #(.WIDTH(SW)) dut_i (.a_i(a5), .b_i(b5), .sub_i(s5), .res_o(r5), .ovf_o(o5));
  smag_addsub #(.WIDTH(8))  dut8_i (.a_i(a8), .b_i(b8), .sub_i(s8), .res_o(r8), .ovf_o(o8));

  typedef struct {
    int         which;
    logic [7:0] res;
    logic       ovf;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // decoded integer reference, result {ovf, res}
  function automatic logic [8:0] model(int w, int a, int b, bit s);
    int mw = w - 1;
    int maxm = (1 << mw) - 1;
    int av = ((a >> mw) & 1) ? -(a & maxm) : (a & maxm);
    int bv = ((b >> mw) & 1) ? -(b & maxm) : (b & maxm);
    int r = s ? av - bv : av + bv;
    int m = (r < 0) ? -r : r;
    int lo = m & maxm;
    int sg = (r < 0 && lo != 0) ? 1 : 0;
    logic [8:0] ret;
    ret = {(m > maxm), 8'(lo | (sg << mw))};
    return ret;
  endfunction

  function automatic string classify(int w, int a, int b, bit s, bit ovf, int res);
    int mw = w - 1;
    int maxm = (1 << mw) - 1;
    bit sa = 1'(a >> mw);
    bit sb = 1'(b >> mw) ^ s;
    if ((res & maxm) == 0) return "R7";
    if (s) return "R6";
    if (sa == sb) return ovf ? "R3" : "R2";
    if ((b & maxm) > (a & maxm)) return "R5";
    return "R4";
  endfunction

  task automatic drive5(int a, int b, bit s);
    logic [8:0] e;
    exp_t it;
    @(negedge clk);
    a5 = SW'(a); b5 = SW'(b); s5 = s;
    e = model(SW, a, b, s);
    it.which = 0; it.res = e[7:0]; it.ovf = e[8];
    it.tag = classify(SW, a, b, s, e[8], int'(e[7:0]));
    q.push_back(it);
  endtask

  task automatic drive8(logic [7:0] a, logic [7:0] b, bit s, logic [7:0] er, bit eo, string tag);
    exp_t it;
    @(negedge clk);
    a8 = a; b8 = b; s8 = s;
    it.which = 1; it.res = er; it.ovf = eo; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compare at the next rising edge, half a period after drive
  always @(posedge clk) begin
    if (q.size() > 0) begin
      exp_t it;
      logic [7:0] ar;
      logic ao;
      it = q.pop_front();
      ar = (it.which == 0) ? {3'b000, r5} : r8;
      ao = (it.which == 0) ? o5 : o8;
      checks++;
      if (ar !== it.res || ao !== it.ovf) begin
        errors++;
        $display("FAIL %s w%0d: res=%h ovf=%b expected res=%h ovf=%b",
                 it.tag, it.which, ar, ao, it.res, it.ovf);
      end
    end
  end

  initial begin
    a5 = '0; b5 = '0; s5 = 1'b0;
    a8 = '0; b8 = '0; s8 = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // quiescent state: zero operands give positive zero (R1)
    drive8(8'h00, 8'h00, 1'b0, 8'h00, 1'b0, "R1");
    // exhaustive sweep at reduced width (R2..R7)
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < (1 << SW); a++)
        for (int b = 0; b < (1 << SW); b++)
          drive5(a, b, 1'(s));
    // directed 8-bit vectors
    drive8(8'h19, 8'hA5, 1'b0, 8'h8C, 1'b0, "R5");  // +25 + -37 = -12
    drive8(8'h89, 8'h09, 1'b0, 8'h00, 1'b0, "R7");  // -9 + 9, positive zero
    drive8(8'h89, 8'h09, 1'b1, 8'h92, 1'b0, "R6");  // -9 - 9 = -18
    drive8(8'h89, 8'h89, 1'b0, 8'h92, 1'b0, "R1");  // minus nine encoding
    drive8(8'h41, 8'h41, 1'b0, 8'h02, 1'b1, "R3");  // 65+65 wraps, flag
    drive8(8'hC0, 8'hC0, 1'b0, 8'h00, 1'b1, "R3");  // -64 + -64 wraps to +0
    drive8(8'h7F, 8'h01, 1'b1, 8'h7E, 1'b0, "R4");  // 127 - 1
    drive8(8'h7F, 8'h81, 1'b1, 8'h00, 1'b1, "R6");  // 127 - (-1) overflows
    drive8(8'h05, 8'h7F, 1'b1, 8'hFA, 1'b0, "R5");  // 5 - 127 = -122
    drive8(8'h23, 8'h14, 1'b0, 8'h37, 1'b0, "R2");  // 35 + 20
    drive8(8'h80, 8'h80, 1'b1, 8'h00, 1'b0, "R7");  // -0 - -0
    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule